// File: doc/BRIEF.md
# Frame and Row Overhead Timer

This block times the two overhead phases of an image sensor readout sequencer: the frame overhead, when the pixel storage node is released before the first row, and the row overhead, when one selected row is moved onto the column sampling stage. It runs from a fast input clock and produces a sensor-rate tick at one quarter of that rate. Every interval is counted in sensor ticks, and every output changes only on a tick.

A frame request starts a frame-overhead interval. The memory-control line drops, and the interval length is the programmed frame value times four ticks. When it ends, a one-tick row clock pulse starts the first row-overhead interval. The row interval lasts the programmed row value plus two ticks. In reduced mode it is a fixed nine ticks. A line-sync strobe closes each row interval. Further rows are started by row requests. Two status flags follow the intervals and drop one tick early, which gives external logic a lead of one sensor clock before each interval ends.

Top module: `ovht_timer`

## Requirements
- R1: `sen_tick` is high for one input clock in every four. Outputs change only on an input clock edge at which the internal tick is active.
- R2: After reset, `mem_ctrl` is 1, and `frame_flag`, `row_flag`, `row_clk` and `line_sync` are 0.
- R3: An accepted frame request drives `mem_ctrl` low on a tick. It stays low for exactly 4*`frame_timer` ticks and then returns high.
- R4: `frame_flag` rises on the tick where `mem_ctrl` falls. It drops one tick before `mem_ctrl` returns high.
- R5: On the tick where `mem_ctrl` returns high, `row_clk` is high for exactly one tick. That tick starts the first row interval.
- R6: With `reduced_mode`=0, a row interval lasts `row_timer`+2 ticks. `row_flag` is high from its first tick and drops one tick before the end. `line_sync` is high only during the interval's last tick, and its fall marks the end.
- R7: With `reduced_mode`=1, a row interval lasts nine ticks, whatever `row_timer` holds.
- R8: A `frame_timer` of 0 gives a frame interval of one tick, and `frame_flag` stays 0 throughout.
- R9: Timer and mode inputs are sampled only on the tick that starts an interval. Changes during the interval do not change its length.
- R10: A row request while no interval runs starts a row interval with a `row_clk` pulse and leaves `mem_ctrl` high.
- R11: Requests that arrive while an interval runs are dropped. When frame and row requests are pending together, the frame request wins and the row request is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, four times the sensor rate |
| rst | input | 1 | Synchronous active-high reset |
| frame_req | input | 1 | One-cycle request to start a frame-overhead interval |
| row_req | input | 1 | One-cycle request to start a row-overhead interval |
| frame_timer | input | FT_W | Frame overhead value, in units of four ticks |
| row_timer | input | RT_W | Row overhead value, length is this plus two ticks |
| reduced_mode | input | 1 | 1 selects the fixed short row interval |
| sen_tick | output | 1 | Sensor clock enable, one input clock wide |
| mem_ctrl | output | 1 | Memory-control line, low during frame overhead |
| row_clk | output | 1 | Row clock pulse, one tick wide, starts a row interval |
| line_sync | output | 1 | Line-sync strobe, high during a row interval's last tick |
| frame_flag | output | 1 | Frame overhead status, drops one tick early |
| row_flag | output | 1 | Row overhead status, drops one tick early |

## Verification
The hardest case to reach from the ports is a timer change that lands in the middle of a running interval, checked against the tick on which the flag falls. The stimulus lines up with the sensor tick seen on `sen_tick`. It then rewrites `frame_timer` during the frame interval and `row_timer` and `reduced_mode` during the row interval, and compares every tick against the lengths sampled at the start. Dropped requests are checked the same way: a frame request is issued during a row interval, and `mem_ctrl` is watched for several ticks after the row ends to confirm that nothing starts.

// File: rtl/ovht_pkg.sv
package ovht_pkg;
  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_FOT  = 2'd1,
    ST_ROT  = 2'd2
  } ovht_state_e;
endpackage

// File: rtl/ovht_tick_div.sv
module ovht_tick_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      cnt_q <= (cnt_q == CNT_W'(DIV - 1)) ? '0 : cnt_q + 1'b1;
      tick  <= (cnt_q == CNT_W'(DIV - 2));
    end
  end

  // R1: enable pulse is one input clock wide
  a_r1_tick_single: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/ovht_down_cnt.sv
module ovht_down_cnt #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] rem,
  output logic         is_zero,
  output logic         is_one
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rem <= '0;
    end else if (load) begin
      rem <= load_val;
    end else if (step && (rem != '0)) begin
      rem <= rem - 1'b1;
    end
  end

  assign is_zero = (rem == '0);
  assign is_one  = (rem == W'(1));

  // R9: a running count only moves downward and never wraps
  a_r9_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (!load && (rem == '0)) |=> (rem == '0));
endmodule

// File: rtl/ovht_timer.sv
module ovht_timer
  import ovht_pkg::*;
#(
  parameter int FT_W        = 8,
  parameter int RT_W        = 8,
  parameter int REDUCED_LEN = 9,
  parameter int DIV         = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            frame_req,
  input  logic            row_req,
  input  logic [FT_W-1:0] frame_timer,
  input  logic [RT_W-1:0] row_timer,
  input  logic            reduced_mode,
  output logic            sen_tick,
  output logic            mem_ctrl,
  output logic            row_clk,
  output logic            line_sync,
  output logic            frame_flag,
  output logic            row_flag
);
  localparam int FL_W = FT_W + 2;
  localparam int RL_W = RT_W + 1;
  localparam int CW   = ((FL_W > RL_W) ? FL_W : RL_W) + 1;

  ovht_state_e   state_q;
  logic          pend_f_q, pend_r_q;
  logic          frame_go, row_go, fot_done;
  logic          cnt_load, cnt_zero, cnt_one;
  logic [CW-1:0] cnt_val, cnt_rem, fot_m1, rot_m1;

  ovht_tick_div #(.DIV(DIV)) u_div (
    .clk  (clk),
    .rst  (rst),
    .tick (sen_tick)
  );

  // interval length minus one, sampled only when an interval starts
  always_comb begin
    fot_m1 = (frame_timer == '0) ? '0
           : (({{(CW-FT_W){1'b0}}, frame_timer}) << 2) - CW'(1);
    rot_m1 = reduced_mode ? CW'(REDUCED_LEN - 1)
           : {{(CW-RT_W){1'b0}}, row_timer} + CW'(1);
  end

  always_comb begin
    frame_go = sen_tick && (state_q == ST_WAIT) && (frame_req || pend_f_q);
    row_go   = sen_tick && (state_q == ST_WAIT) && !frame_go && (row_req || pend_r_q);
    fot_done = sen_tick && (state_q == ST_FOT) && cnt_zero;
    cnt_load = frame_go || row_go || fot_done;
    cnt_val  = frame_go ? fot_m1 : rot_m1;
  end

  ovht_down_cnt #(.W(CW)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .step     (sen_tick),
    .load     (cnt_load),
    .load_val (cnt_val),
    .rem      (cnt_rem),
    .is_zero  (cnt_zero),
    .is_one   (cnt_one)
  );

  // request capture: only while idle, cleared by any accepted start
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_f_q <= 1'b0;
      pend_r_q <= 1'b0;
    end else if (frame_go || row_go) begin
      pend_f_q <= 1'b0;
      pend_r_q <= 1'b0;
    end else if (state_q == ST_WAIT) begin
      pend_f_q <= pend_f_q || frame_req;
      pend_r_q <= pend_r_q || row_req;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_WAIT;
      mem_ctrl   <= 1'b1;
      row_clk    <= 1'b0;
      line_sync  <= 1'b0;
      frame_flag <= 1'b0;
      row_flag   <= 1'b0;
    end else if (sen_tick) begin
      row_clk <= 1'b0;
      unique case (state_q)
        ST_WAIT: begin
          if (frame_go) begin
            state_q    <= ST_FOT;
            mem_ctrl   <= 1'b0;
            frame_flag <= (fot_m1 != '0);
          end else if (row_go) begin
            state_q  <= ST_ROT;
            row_clk  <= 1'b1;
            row_flag <= 1'b1;
          end
        end
        ST_FOT: begin
          if (cnt_zero) begin
            state_q    <= ST_ROT;
            mem_ctrl   <= 1'b1;
            frame_flag <= 1'b0;
            row_clk    <= 1'b1;
            row_flag   <= 1'b1;
          end else begin
            frame_flag <= !cnt_one;
          end
        end
        ST_ROT: begin
          if (cnt_zero) begin
            state_q   <= ST_WAIT;
            line_sync <= 1'b0;
            row_flag  <= 1'b0;
          end else begin
            row_flag  <= !cnt_one;
            line_sync <= cnt_one;
          end
        end
        default: state_q <= ST_WAIT;
      endcase
    end
  end

  // R1: nothing moves between sensor ticks
  a_r1_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
    !sen_tick |=> $stable({mem_ctrl, row_clk, line_sync, frame_flag, row_flag}));
  // R4: frame status only while memory-control is low
  a_r4_flag_inside_fot: assert property (@(posedge clk) disable iff (rst)
    frame_flag |-> !mem_ctrl);
  // R6: the two status flags never overlap
  a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(frame_flag && row_flag));
  // R5: end of frame overhead launches a row clock
  a_r5_rowclk_at_fot_end: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_ctrl) |-> row_clk);
  // R6: line sync only after row flag has dropped
  a_r6_sync_last_tick: assert property (@(posedge clk) disable iff (rst)
    line_sync |-> !row_flag);
  // R3: frame start carries no row activity
  a_r3_clean_fot_start: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_ctrl) |-> (!row_flag && !row_clk && !line_sync));
endmodule

// File: tb/sim_ovht_timer.sv
module sim_ovht_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_req = 1'b0, row_req = 1'b0, reduced_mode = 1'b0;
  logic [7:0] frame_timer = '0, row_timer = '0;
  logic       sen_tick, mem_ctrl, row_clk, line_sync, frame_flag, row_flag;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ovht_timer u0 (
    .clk(clk), .rst(rst), .frame_req(frame_req), .row_req(row_req),
    .frame_timer(frame_timer), .row_timer(row_timer), .reduced_mode(reduced_mode),
    .sen_tick(sen_tick), .mem_ctrl(mem_ctrl), .row_clk(row_clk),
    .line_sync(line_sync), .frame_flag(frame_flag), .row_flag(row_flag)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // advance to the negedge right after the next tick-enabled posedge
  task automatic tick_edge();
    do @(negedge clk); while (sen_tick !== 1'b1);
    @(negedge clk);
  endtask

  task automatic pulse(input bit f, input bit r);
    frame_req = f; row_req = r;
    @(negedge clk);
    frame_req = 1'b0; row_req = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tick_edge();
  endtask

  // full frame: FOT then first ROT, checked tick by tick
  task automatic t_frame(input int f, input int r, input bit red, input bit mid, input string tg);
    int fl, rl;
    fl = (f == 0) ? 1 : 4 * f;
    rl = red ? 9 : r + 2;
    frame_timer = 8'(f); row_timer = 8'(r); reduced_mode = red;
    pulse(1'b1, 1'b0);
    tick_edge();
    for (int t = 0; t < fl; t++) begin
      chk(tg, "R3 mem_ctrl in fot", int'(mem_ctrl), 0);
      chk(tg, "R4 frame_flag", int'(frame_flag), (t < fl - 1) ? 1 : 0);
      chk(tg, "R5 row_clk in fot", int'(row_clk), 0);
      if (mid && t == 1) frame_timer = 8'(f + 3);
      tick_edge();
    end
    chk(tg, "R3 mem_ctrl at end", int'(mem_ctrl), 1);
    chk(tg, "R5 row_clk at end", int'(row_clk), 1);
    chk(tg, "R6 row_flag start", int'(row_flag), 1);
    chk(tg, "R4 frame_flag at end", int'(frame_flag), 0);
    for (int t = 1; t <= rl; t++) begin
      if (mid && t == 1) begin row_timer = 8'(r + 5); reduced_mode = ~red; end
      tick_edge();
      chk(tg, "R5 row_clk single", int'(row_clk), 0);
      chk(tg, "R6 row_flag", int'(row_flag), (t < rl - 1) ? 1 : 0);
      chk(tg, "R6 line_sync", int'(line_sync), (t == rl - 1) ? 1 : 0);
      chk(tg, "R6 mem_ctrl high", int'(mem_ctrl), 1);
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R2", "mem_ctrl", int'(mem_ctrl), 1);
    chk("R2", "frame_flag", int'(frame_flag), 0);
    chk("R2", "row_flag", int'(row_flag), 0);
    chk("R2", "row_clk", int'(row_clk), 0);
    chk("R2", "line_sync", int'(line_sync), 0);
  endtask

  task automatic t_tick_period();
    int n;
    do @(negedge clk); while (sen_tick !== 1'b1);
    n = 0;
    do begin @(negedge clk); n++; end while (sen_tick !== 1'b1);
    chk("R1", "tick period", n, 4);
    @(negedge clk);
  endtask

  task automatic t_row_only();
    row_timer = 8'd1; reduced_mode = 1'b0;
    pulse(1'b0, 1'b1);
    tick_edge();
    chk("R10", "row_clk", int'(row_clk), 1);
    chk("R10", "row_flag", int'(row_flag), 1);
    chk("R10", "mem_ctrl", int'(mem_ctrl), 1);
    for (int t = 1; t <= 3; t++) begin
      tick_edge();
      chk("R10", "row_flag", int'(row_flag), (t < 2) ? 1 : 0);
      chk("R10", "line_sync", int'(line_sync), (t == 2) ? 1 : 0);
      chk("R10", "mem_ctrl", int'(mem_ctrl), 1);
    end
  endtask

  task automatic t_ignore_busy();
    row_timer = 8'd4; reduced_mode = 1'b0;
    frame_timer = 8'd1;
    pulse(1'b0, 1'b1);
    tick_edge();
    tick_edge();
    pulse(1'b1, 1'b0);
    for (int t = 2; t <= 6; t++) tick_edge();
    chk("R11", "row ended", int'(row_flag | line_sync), 0);
    for (int k = 0; k < 3; k++) begin
      tick_edge();
      chk("R11", "no frame after drop", int'(mem_ctrl), 1);
      chk("R11", "no row after drop", int'(row_clk), 0);
    end
    pulse(1'b1, 1'b1);
    tick_edge();
    chk("R11", "frame wins mem_ctrl", int'(mem_ctrl), 0);
    chk("R11", "frame wins row_clk", int'(row_clk), 0);
    do_reset();
  endtask

  initial begin
    t_reset_state();
    t_tick_period();
    t_frame(2, 3, 1'b0, 1'b0, "R3");
    t_frame(1, 0, 1'b0, 1'b0, "R6");
    t_frame(0, 2, 1'b0, 1'b0, "R8");
    t_frame(1, 3, 1'b1, 1'b0, "R7");
    t_frame(2, 1, 1'b0, 1'b1, "R9");
    t_row_only();
    t_ignore_busy();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule